// File: doc/BRIEF.md
# Parity-Carrying Bridge Data Path

This block is the data path between a north bus that carries no parity and a south bus that protects every byte with an even parity bit. Data coming from the north gets parity generated as it enters the block. That parity is stored beside the data in a small FIFO, and the south side drives it exactly as stored. Data coming from the south is stored with the parity bits it arrived with. Those bits are checked only when the entry leaves toward the north.

An inbound write that fails the check is still forwarded north, and the error is logged. An inbound read completion that fails the check is turned into an abort on the north side, and the error is logged. On the address side, the block generates byte-wise parity for the address it drives south. It checks incoming address parity only in the cycle in which it claims a south write.

Three sticky error flags record the failures. Each flag is cleared by writing a one to it. A test input can flip one chosen parity bit of the entry being written into either FIFO, so both error paths can be reached on purpose.

Top module: `bridge_par_path`

## Requirements
- R1: An outbound entry accepted on the north side appears on the south side with unchanged data and kind. `sout_dpar[i]` is the XOR of data bits 8i+7..8i, which gives even parity per byte. The entry becomes visible one clock after it is accepted.
- R2: The south parity is driven as stored and is not recomputed. When `inj_en` is high in the cycle of acceptance, `sout_dpar` shows bit `inj_sel` inverted.
- R3: An inbound entry whose stored parity matches its data reaches `nout_data`/`nout_kind` unchanged. It raises no `nout_abort` and sets no error flag.
- R4: An inbound write (kind 0) whose parity does not match is still presented with `nout_abort` low. When it is taken, it sets `err_status[1]`.
- R5: An inbound read completion (kind 1) whose parity does not match is presented with `nout_abort` high. When it is taken, it sets `err_status[2]`.
- R6: `sad_addr` equals `nad_addr`. `sad_apar[k]` for k=0..3 is the XOR of address byte k, and `sad_apar[4]` is the XOR of address bits 35..32.
- R7: An address parity mismatch between `sin_addr` and `sin_apar` (same grouping as R6) sets `err_status[0]` only in a cycle with `sin_claim` high. Without a claim, the mismatch has no effect.
- R8: Error flags are sticky until a one is written to the matching bit of `err_clr`. When a flag is set and cleared in the same cycle, the set wins.
- R9: Each direction buffers up to DEPTH (4) entries in order. The input ready signal is low exactly while the buffer is full, and an offer made while full is dropped.
- R10: After reset, both output valids are low, both input readies are high and `err_status` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nin_valid | input | 1 | North outbound entry offered |
| nin_ready | output | 1 | Outbound buffer can accept |
| nin_data | input | 128 | North outbound data |
| nin_kind | input | 1 | 0 write, 1 read completion |
| sout_valid | output | 1 | South outbound entry available |
| sout_ready | input | 1 | South side takes entry |
| sout_data | output | 128 | South outbound data |
| sout_dpar | output | 16 | Stored byte parity driven south |
| sout_kind | output | 1 | Kind of the outbound entry |
| sin_valid | input | 1 | South inbound entry offered |
| sin_ready | output | 1 | Inbound buffer can accept |
| sin_data | input | 128 | South inbound data |
| sin_dpar | input | 16 | Received byte parity |
| sin_kind | input | 1 | 0 write, 1 read completion |
| nout_valid | output | 1 | North inbound entry available |
| nout_ready | input | 1 | North side takes entry |
| nout_data | output | 128 | Inbound data toward north |
| nout_kind | output | 1 | Kind of the inbound entry |
| nout_abort | output | 1 | Read completion replaced by abort |
| nad_addr | input | 36 | Address the block drives south |
| sad_addr | output | 36 | Address on the south bus |
| sad_apar | output | 5 | Generated address parity |
| sin_claim | input | 1 | Block claims a south write this cycle |
| sin_addr | input | 36 | Incoming south address |
| sin_apar | input | 5 | Incoming address parity |
| err_clr | input | 3 | Write-one-to-clear strobes |
| err_status | output | 3 | Sticky flags: bit0 address, bit1 write data, bit2 read completion |
| inj_en | input | 1 | Flip one stored parity bit on write |
| inj_sel | input | 4 | Index of the parity bit to flip |

## Verification
An error can be logged in the same cycle in which software clears the same flag. This can happen with a bad claimed address or with a bad inbound entry leaving the block. The bench provokes both cases by raising the matching `err_clr` bit on the very edge that records the error. It then requires the flag to read one afterwards, and to read zero only after a later clear that has no error beside it. Pushes and pops that share a cycle at the full boundary are judged by the fill-and-drain sequence: the dropped fifth offer must never appear on the south side.

// File: rtl/bpb_pkg.sv
package bpb_pkg;
   typedef enum logic {
      KIND_WRITE = 1'b0,
      KIND_RDCPL = 1'b1
   } xfer_kind_e;

   localparam int ERR_ADDR  = 0;
   localparam int ERR_WDATA = 1;
   localparam int ERR_RDCPL = 2;
   localparam int ERR_W     = 3;
endpackage

// File: rtl/bpb_par_gen.sv
module bpb_par_gen #(
   parameter int W = 128,
   parameter int G = 8,
   localparam int N = (W + G - 1) / G
) (
   input  logic [W-1:0] din,
   output logic [N-1:0] par
);
   for (genvar g = 0; g < N; g++) begin : g_grp
      localparam int LO = g * G;
      localparam int HI = ((g + 1) * G > W) ? W - 1 : (g + 1) * G - 1;
      assign par[g] = ^din[HI:LO];
   end
endmodule

// File: rtl/bpb_fifo.sv
module bpb_fifo #(
   parameter int W     = 145,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("bpb_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [PW:0]  wr_ptr, rd_ptr;
   logic         full, empty, push, pop;

   assign empty = (wr_ptr == rd_ptr);
   assign full  = (wr_ptr[PW] != rd_ptr[PW]) && (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);
   assign in_ready  = !full;
   assign out_valid = !empty;
   assign push = in_valid && !full;
   assign pop  = out_ready && !empty;
   assign out_data = mem[rd_ptr[PW-1:0]];

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr[PW-1:0]] <= in_data;
   end
endmodule

// File: rtl/bpb_err_log.sv
module bpb_err_log #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] status
);
   always_ff @(posedge clk) begin
      if (rst) status <= '0;
      else     status <= (status & ~clr) | set;
   end
endmodule

// File: rtl/bridge_par_path.sv
module bridge_par_path
   import bpb_pkg::*;
#(
   parameter int AW    = 36,
   parameter int DW    = 128,
   parameter int GB    = 8,
   parameter int DEPTH = 4,
   localparam int DPW  = (DW + GB - 1) / GB,
   localparam int APW  = (AW + GB - 1) / GB,
   localparam int SELW = $clog2(DPW)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             nin_valid,
   output logic             nin_ready,
   input  logic [DW-1:0]    nin_data,
   input  logic             nin_kind,
   output logic             sout_valid,
   input  logic             sout_ready,
   output logic [DW-1:0]    sout_data,
   output logic [DPW-1:0]   sout_dpar,
   output logic             sout_kind,
   input  logic             sin_valid,
   output logic             sin_ready,
   input  logic [DW-1:0]    sin_data,
   input  logic [DPW-1:0]   sin_dpar,
   input  logic             sin_kind,
   output logic             nout_valid,
   input  logic             nout_ready,
   output logic [DW-1:0]    nout_data,
   output logic             nout_kind,
   output logic             nout_abort,
   input  logic [AW-1:0]    nad_addr,
   output logic [AW-1:0]    sad_addr,
   output logic [APW-1:0]   sad_apar,
   input  logic             sin_claim,
   input  logic [AW-1:0]    sin_addr,
   input  logic [APW-1:0]   sin_apar,
   input  logic [ERR_W-1:0] err_clr,
   output logic [ERR_W-1:0] err_status,
   input  logic             inj_en,
   input  logic [SELW-1:0]  inj_sel
);
   localparam int EW = 1 + DW + DPW;

   if (DPW < 2 || GB < 1) begin : g_bad_width
      $error("bridge_par_path: need at least two data parity groups");
   end

   // parity flip mask for the test input, applied on buffer write
   logic [DPW-1:0] flip;
   assign flip = inj_en ? (DPW'(1) << inj_sel) : '0;

   // ---------------- outbound: parity made on entry ----------------
   logic [DPW-1:0] out_gen;
   logic [EW-1:0]  ob_wr, ob_rd;

   bpb_par_gen #(.W(DW), .G(GB)) u_ob_gen (.din(nin_data), .par(out_gen));

   assign ob_wr = {nin_kind, nin_data, out_gen ^ flip};

   bpb_fifo #(.W(EW), .DEPTH(DEPTH)) u_ob_fifo (
      .clk(clk), .rst(rst),
      .in_valid(nin_valid), .in_ready(nin_ready), .in_data(ob_wr),
      .out_valid(sout_valid), .out_ready(sout_ready), .out_data(ob_rd)
   );

   assign sout_kind = ob_rd[EW-1];
   assign sout_data = ob_rd[DPW +: DW];
   assign sout_dpar = ob_rd[DPW-1:0];

   // ---------------- inbound: parity carried, checked on exit ----------------
   logic [EW-1:0]  ib_wr, ib_rd;
   logic [DPW-1:0] ib_par, ib_chk;
   logic           ib_perr, ib_take;

   assign ib_wr = {sin_kind, sin_data, sin_dpar ^ flip};

   bpb_fifo #(.W(EW), .DEPTH(DEPTH)) u_ib_fifo (
      .clk(clk), .rst(rst),
      .in_valid(sin_valid), .in_ready(sin_ready), .in_data(ib_wr),
      .out_valid(nout_valid), .out_ready(nout_ready), .out_data(ib_rd)
   );

   assign nout_kind = ib_rd[EW-1];
   assign nout_data = ib_rd[DPW +: DW];
   assign ib_par    = ib_rd[DPW-1:0];

   bpb_par_gen #(.W(DW), .G(GB)) u_ib_chk (.din(nout_data), .par(ib_chk));

   assign ib_perr    = |(ib_chk ^ ib_par);
   assign ib_take    = nout_valid && nout_ready;
   assign nout_abort = nout_valid && (nout_kind == KIND_RDCPL) && ib_perr;

   // ---------------- address parity ----------------
   logic [APW-1:0] a_in_gen;

   assign sad_addr = nad_addr;
   bpb_par_gen #(.W(AW), .G(GB)) u_aout_gen (.din(nad_addr), .par(sad_apar));
   bpb_par_gen #(.W(AW), .G(GB)) u_ain_gen  (.din(sin_addr), .par(a_in_gen));

   // ---------------- sticky error log ----------------
   logic [ERR_W-1:0] err_set;

   always_comb begin
      err_set            = '0;
      err_set[ERR_ADDR]  = sin_claim && (a_in_gen != sin_apar);
      err_set[ERR_WDATA] = ib_take && ib_perr && (nout_kind == KIND_WRITE);
      err_set[ERR_RDCPL] = ib_take && ib_perr && (nout_kind == KIND_RDCPL);
   end

   bpb_err_log #(.N(ERR_W)) u_log (
      .clk(clk), .rst(rst), .set(err_set), .clr(err_clr), .status(err_status)
   );
endmodule

// File: rtl/bridge_par_path_chk.sv
module bridge_par_path_chk #(
   parameter int AW    = 36,
   parameter int DW    = 128,
   parameter int GB    = 8,
   parameter int DEPTH = 4,
   localparam int APW  = (AW + GB - 1) / GB
) (
   input logic           clk,
   input logic           rst,
   input logic           nin_valid,
   input logic           nin_ready,
   input logic           sout_valid,
   input logic           sout_ready,
   input logic           nout_valid,
   input logic           nout_kind,
   input logic           nout_abort,
   input logic [AW-1:0]  sad_addr,
   input logic [APW-1:0] sad_apar,
   input logic           sin_claim,
   input logic [2:0]     err_clr,
   input logic [2:0]     err_status
);
   function automatic logic [APW-1:0] apar_of(input logic [AW-1:0] a);
      logic [APW-1:0] p;
      p = '0;
      for (int i = 0; i < AW; i++) p[i / GB] = p[i / GB] ^ a[i];
      return p;
   endfunction

   // independent occupancy model of the outbound buffer
   logic [$clog2(DEPTH+1)-1:0] occ;
   always_ff @(posedge clk) begin
      if (rst) occ <= '0;
      else     occ <= occ + (nin_valid && nin_ready) - (sout_valid && sout_ready);
   end

   assert_ready_full_R9: assert property (@(posedge clk) disable iff (rst)
      nin_ready == (occ < DEPTH));

   assert_abort_rdcpl_R5: assert property (@(posedge clk) disable iff (rst)
      nout_abort |-> (nout_valid && nout_kind));

   assert_write_no_abort_R4: assert property (@(posedge clk) disable iff (rst)
      (nout_valid && !nout_kind) |-> !nout_abort);

   assert_addr_parity_R6: assert property (@(posedge clk) disable iff (rst)
      sad_apar == apar_of(sad_addr));

   assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((($past(err_status) & ~$past(err_clr)) & ~err_status) == 3'b000));

   assert_claim_only_R7: assert property (@(posedge clk) disable iff (rst)
      (!sin_claim && !err_clr[0]) |=> (err_status[0] == $past(err_status[0])));

   assert_reset_state_R10: assert property (@(posedge clk)
      rst |=> (!sout_valid && !nout_valid && err_status == 3'b000));
endmodule

bind bridge_par_path bridge_par_path_chk #(
   .AW(AW), .DW(DW), .GB(GB), .DEPTH(DEPTH)
) u_chk (.*);

// File: tb/bridge_par_path_bench.sv
`timescale 1ns/1ps
module bridge_par_path_bench;
   localparam int DW = 128;
   localparam int AW = 36;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic          nin_valid = 0, nin_kind = 0, sout_ready = 0;
   logic [DW-1:0] nin_data = '0;
   logic          nin_ready, sout_valid, sout_kind;
   logic [DW-1:0] sout_data;
   logic [15:0]   sout_dpar;
   logic          sin_valid = 0, sin_kind = 0, nout_ready = 0;
   logic [DW-1:0] sin_data = '0;
   logic [15:0]   sin_dpar = '0;
   logic          sin_ready, nout_valid, nout_kind, nout_abort;
   logic [DW-1:0] nout_data;
   logic [AW-1:0] nad_addr = '0, sin_addr = '0;
   logic [AW-1:0] sad_addr;
   logic [4:0]    sad_apar;
   logic [4:0]    sin_apar = '0;
   logic          sin_claim = 0;
   logic [2:0]    err_clr = '0;
   logic [2:0]    err_status;
   logic          inj_en = 0;
   logic [3:0]    inj_sel = '0;

   bridge_par_path u_bridge_par_path (.*);

   int checks = 0;
   int errors = 0;

   task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [15:0] dpar_of(input logic [DW-1:0] d);
      logic [15:0] p;
      for (int b = 0; b < 16; b++) p[b] = ^d[b*8 +: 8];
      return p;
   endfunction

   function automatic logic [4:0] apar_of(input logic [AW-1:0] a);
      logic [4:0] p;
      for (int b = 0; b < 4; b++) p[b] = ^a[b*8 +: 8];
      p[4] = ^a[35:32];
      return p;
   endfunction

   typedef struct packed {
      logic        inb;   // 1: south to north
      logic        kind;  // 0 write, 1 read completion
      logic [31:0] seed;
      logic        bad;
      logic [3:0]  sel;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b0, 1'b0, 32'h0000_0000, 1'b0, 4'd0},
      '{1'b0, 1'b1, 32'hDEAD_BEEF, 1'b0, 4'd0},
      '{1'b0, 1'b0, 32'h0102_0408, 1'b1, 4'd5},
      '{1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 4'd15},
      '{1'b1, 1'b0, 32'h1357_9BDF, 1'b0, 4'd0},
      '{1'b1, 1'b1, 32'hA5A5_0F0F, 1'b0, 4'd0},
      '{1'b1, 1'b0, 32'h8000_0001, 1'b1, 4'd3},
      '{1'b1, 1'b1, 32'h7E7E_7E7E, 1'b1, 4'd12}
   };

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      tick();

      // R10 reset state
      chk(!sout_valid && !nout_valid, "R10 valids after reset", {sout_valid, nout_valid}, 0);
      chk(nin_ready && sin_ready, "R10 readies after reset", {nin_ready, sin_ready}, 2'b11);
      chk(err_status == 3'b000, "R10 err_status after reset", err_status, 0);

      // vector table
      for (int v = 0; v < 8; v++) begin
         logic [DW-1:0] d;
         logic [15:0]   flipm;
         d = {4{VEC[v].seed}};
         flipm = VEC[v].bad ? (16'd1 << VEC[v].sel) : 16'd0;
         err_clr = 3'b111;
         tick();
         err_clr = 3'b000;
         if (!VEC[v].inb) begin
            nin_valid = 1; nin_data = d; nin_kind = VEC[v].kind;
            inj_en = VEC[v].bad; inj_sel = VEC[v].sel;
            tick();
            nin_valid = 0; inj_en = 0;
            chk(sout_valid && sout_data == d && sout_kind == VEC[v].kind,
                "R1 outbound data/kind", sout_data, d);
            chk(sout_dpar == (dpar_of(d) ^ flipm),
                VEC[v].bad ? "R2 stored parity driven as held" : "R1 outbound parity",
                sout_dpar, dpar_of(d) ^ flipm);
            sout_ready = 1;
            tick();
            sout_ready = 0;
            chk(!sout_valid, "R9 outbound drained", sout_valid, 0);
         end else begin
            logic [2:0] exp_err;
            sin_valid = 1; sin_data = d; sin_kind = VEC[v].kind;
            sin_dpar = dpar_of(d) ^ flipm;
            tick();
            sin_valid = 0;
            chk(nout_valid && nout_data == d && nout_kind == VEC[v].kind,
                "R3 inbound data/kind", nout_data, d);
            chk(nout_abort == (VEC[v].kind & VEC[v].bad),
                VEC[v].kind ? "R5 abort on bad completion" : "R4 write not aborted",
                nout_abort, VEC[v].kind & VEC[v].bad);
            nout_ready = 1;
            tick();
            nout_ready = 0;
            exp_err = {VEC[v].kind & VEC[v].bad, ~VEC[v].kind & VEC[v].bad, 1'b0};
            chk(err_status == exp_err,
                VEC[v].bad ? (VEC[v].kind ? "R5 completion error logged" : "R4 write error logged")
                           : "R3 clean entry logs nothing",
                err_status, exp_err);
         end
      end

      // R2 via test input on the inbound path: write with flipped bit
      err_clr = 3'b111; tick(); err_clr = 3'b000;
      sin_valid = 1; sin_data = {4{32'h0F0F_1234}}; sin_kind = 0;
      sin_dpar = dpar_of({4{32'h0F0F_1234}}); inj_en = 1; inj_sel = 4'd9;
      tick();
      sin_valid = 0; inj_en = 0;
      chk(nout_valid && !nout_abort, "R4 injected write still forwarded", nout_abort, 0);
      nout_ready = 1; err_clr = 3'b010;   // R8 set and clear in the same cycle
      tick();
      nout_ready = 0; err_clr = 3'b000;
      chk(err_status == 3'b010, "R8 set wins over clear (write data)", err_status, 3'b010);
      tick();
      chk(err_status == 3'b010, "R8 flag sticky", err_status, 3'b010);
      err_clr = 3'b010; tick(); err_clr = 3'b000;
      chk(err_status == 3'b000, "R8 write-one clears", err_status, 0);

      // R6 address parity
      nad_addr = 36'h0_0000_0000; #1;
      chk(sad_apar == 5'b00000 && sad_addr == nad_addr, "R6 apar zero", sad_apar, 0);
      nad_addr = 36'hF_0000_0001; #1;
      chk(sad_apar == 5'b00001, "R6 apar upper group even", sad_apar, 5'b00001);
      nad_addr = 36'h1_0300_0007; #1;
      chk(sad_apar == 5'b10001, "R6 apar upper group odd", sad_apar, 5'b10001);
      nad_addr = 36'hA_BCDE_F012; #1;
      chk(sad_apar == apar_of(nad_addr), "R6 apar mixed", sad_apar, apar_of(nad_addr));
      @(negedge clk);

      // R7 address check only on claim
      sin_addr = 36'h1_2345_6789;
      sin_apar = ~apar_of(36'h1_2345_6789);
      tick();
      chk(err_status[0] == 1'b0, "R7 mismatch without claim ignored", err_status, 0);
      sin_claim = 1; tick(); sin_claim = 0;
      chk(err_status[0] == 1'b1, "R7 claimed mismatch logged", err_status, 3'b001);
      sin_claim = 1; err_clr = 3'b001; tick(); sin_claim = 0; err_clr = 3'b000;
      chk(err_status[0] == 1'b1, "R8 set wins over clear (address)", err_status, 3'b001);
      err_clr = 3'b001; tick(); err_clr = 3'b000;
      sin_apar = apar_of(sin_addr); sin_claim = 1; tick(); sin_claim = 0;
      chk(err_status == 3'b000, "R7 claimed good parity quiet", err_status, 0);

      // R9 fill and overflow
      for (int i = 0; i < 4; i++) begin
         nin_valid = 1; nin_data = DW'(i + 100); nin_kind = 0;
         tick();
      end
      chk(!nin_ready, "R9 ready low when full", nin_ready, 0);
      nin_data = DW'(999);
      tick();
      nin_valid = 0;
      for (int i = 0; i < 4; i++) begin
         chk(sout_valid && sout_data == DW'(i + 100), "R9 order preserved", sout_data, DW'(i + 100));
         sout_ready = 1; tick(); sout_ready = 0;
      end
      chk(!sout_valid, "R9 offer while full dropped", sout_valid, 0);
      chk(nin_ready, "R9 ready back after drain", nin_ready, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule